// File: doc/BRIEF.md
# Framebuffer Scanout with Per-Row Palette

This block turns a 4096-word, 4-bit frame memory into a stream of 3-bit master-colour codes while the raster generator sweeps the screen. The memory is organised as 64 rows of 64 words. Each word carries two neighbouring pixels of 2 bits each. The raster generator supplies the horizontal pixel position, the row index and a blank flag. The block derives the read address from them, registers the read, and maps each 2-bit pixel through a small palette to one of eight master colours.

The palette is not fixed. Word column 62 of every row lies in the horizontally invisible part of the line. Its two low bits select one of four palettes. A line-phase state machine walks through four states on every scanline:
- `LN_SCAN`: the visible part of the line.
- `LN_GRAB`: the selector word is on the read port and is copied into a pending register.
- `LN_HOLD`: the pending value waits for the end of the line.
- `LN_SWAP`: at pixel position 127 the pending value becomes the active palette.

The transitions are:
- SCAN→GRAB when the incoming position is 124.
- GRAB→HOLD unconditionally.
- HOLD→GRAB on position 124, or HOLD→SWAP on position 127.
- SWAP→GRAB on position 124, otherwise SWAP→SCAN.

The palette therefore changes only at a line boundary. Because a row is shown on several physical scanlines, the first scanline of each row is drawn with the selector read on the last scanline of the row before it.

A CPU-side port writes single words at any time, even while scanout reads.

Top module: `fb_scanout`

## Requirements
- R1: While reset is held, the colour output is 0 (black). After reset the active palette selector is 0 until the first line-end swap.
- R2: A pixel at position x on row y comes from the word at address {y, x[6:1]}. An even x takes bits [1:0] of that word and an odd x takes bits [3:2].
- R3: Colour codes are: 0 black, 1 white, 2 red, 3 green, 4 blue, 5 light green, 6 light blue, 7 light gray. With selector 0, 1 or 2, pixel value 1 gives blue, 2 gives red and 3 gives green. Pixel value 0 gives light gray for selector 0, light blue for selector 1 and light green for selector 2.
- R4: A pixel presented with blank high is output as black, whatever the memory holds.
- R5: The selector is bits [1:0] of word column 62, which is read when x is 124. It becomes active only after the input at x = 127, and it governs from x = 0 of the following scanline. The first scanline of a new row therefore uses the previous row's selector.
- R6: Selector 3 maps pixel value 0 to black and pixel values 1, 2 and 3 to white.
- R7: The colour for the inputs presented before clock edge n appears after clock edge n+1, a latency of two cycles.
- R8: A CPU write stores a 4-bit word at a 12-bit address {row, column} in the same cycle as an unrelated scanout read. A read of the address being written in that cycle returns the old word.
- R9: Bits [3:2] of the selector word have no effect on the palette.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_x | input | 7 | Horizontal pixel position, 0 to 127 |
| row_y | input | 6 | Frame row index |
| blank | input | 1 | High where the raster is not visible |
| cpu_we | input | 1 | CPU write strobe |
| cpu_addr | input | 12 | CPU write address {row, word column} |
| cpu_wdata | input | 4 | CPU write data |
| colour | output | 3 | Master-colour code |

## Verification
The bench keeps its own shadow of the memory and a model of the pending and active palette. It compares every output pixel with that model, two cycles after the inputs.

The central corner case is the first scanline of each row. A design that latched the selector as soon as it was read, or at the start of the row, would paint that scanline in the new palette and give the wrong colour for every zero pixel. Rows whose selector word has nonzero upper bits would show a wrong palette if the decode looked at all four bits. A swapped pixel half within the word would mirror every pixel pair. Writes to the word being read in that same cycle expose a design that forwards write data into the read; writes to other rows expose one that drops either access.

// File: rtl/fbs_pkg.sv
package fbs_pkg;

    // Master colour codes
    typedef enum logic [2:0] {
        C_BLACK  = 3'd0,
        C_WHITE  = 3'd1,
        C_RED    = 3'd2,
        C_GREEN  = 3'd3,
        C_BLUE   = 3'd4,
        C_LGREEN = 3'd5,
        C_LBLUE  = 3'd6,
        C_LGRAY  = 3'd7
    } colour_e;

    // Phases of one scanline as seen by the palette logic
    typedef enum logic [1:0] {
        LN_SCAN,
        LN_GRAB,
        LN_HOLD,
        LN_SWAP
    } line_st_e;

    localparam logic [1:0] SEL_MONO = 2'd3;

    function automatic colour_e map_pixel(input logic [1:0] sel, input logic [1:0] pix);
        colour_e c;
        if (sel == SEL_MONO) begin
            c = (pix == 2'd0) ? C_BLACK : C_WHITE;
        end else begin
            case (pix)
                2'd1:    c = C_BLUE;
                2'd2:    c = C_RED;
                2'd3:    c = C_GREEN;
                default: begin
                    case (sel)
                        2'd0:    c = C_LGRAY;
                        2'd1:    c = C_LBLUE;
                        default: c = C_LGREEN;
                    endcase
                end
            endcase
        end
        return c;
    endfunction

endpackage

// File: rtl/fbs_frame_mem.sv
module fbs_frame_mem #(
    parameter int AW = 12,
    parameter int DW = 4
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] store [DEPTH];

    // Write and read share a clock; the read returns the word held before any same-cycle write
    always_ff @(posedge clk) begin
        if (wr_en) begin
            store[wr_addr] <= wr_data;
        end
        rd_data <= store[rd_addr];
    end

endmodule

// File: rtl/fbs_line_fsm.sv
module fbs_line_fsm
    import fbs_pkg::*;
#(
    parameter int XW    = 7,
    parameter int PAL_X = 124
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [XW-1:0] pix_x,
    input  logic [1:0]    word_sel,
    output logic [1:0]    pal_sel
);
    localparam logic [XW-1:0] GRAB_X = XW'(PAL_X);
    localparam logic [XW-1:0] LAST_X = '1;

    line_st_e   st, st_nx;
    logic [1:0] pending;

    always_comb begin
        st_nx = st;
        unique case (st)
            LN_SCAN: if (pix_x == GRAB_X) st_nx = LN_GRAB;
            LN_GRAB: st_nx = LN_HOLD;
            LN_HOLD: begin
                if (pix_x == GRAB_X)      st_nx = LN_GRAB;
                else if (pix_x == LAST_X) st_nx = LN_SWAP;
            end
            LN_SWAP: st_nx = (pix_x == GRAB_X) ? LN_GRAB : LN_SCAN;
            default: st_nx = LN_SCAN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st <= LN_SCAN;
        else        st <= st_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending <= 2'd0;
            pal_sel <= 2'd0;
        end else begin
            unique case (st)
                LN_GRAB: pending <= word_sel;
                LN_SWAP: pal_sel <= pending;
                default: ;
            endcase
        end
    end

    // R5
    swap_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st != LN_SWAP) |=> $stable(pal_sel));

    // R5
    grab_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == LN_GRAB) |-> ($past(pix_x) == GRAB_X));

endmodule

// File: rtl/fbs_colour_stage.sv
module fbs_colour_stage
    import fbs_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       blank_d,
    input  logic       odd_d,
    input  logic [3:0] word_d,
    input  logic [1:0] pal_sel,
    output colour_e    colour_o
);
    logic [1:0] pix;

    always_comb begin
        pix = odd_d ? word_d[3:2] : word_d[1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n)       colour_o <= C_BLACK;
        else if (blank_d) colour_o <= C_BLACK;
        else              colour_o <= map_pixel(pal_sel, pix);
    end

    // R4
    blank_black_chk: assert property (@(posedge clk) disable iff (!rst_n)
        blank_d |=> (colour_o == C_BLACK));

    // R6
    mono_pal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!blank_d && pal_sel == SEL_MONO) |=> (colour_o == C_BLACK || colour_o == C_WHITE));

    // R3
    colour_pal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!blank_d && pal_sel != SEL_MONO) |=> (colour_o != C_BLACK && colour_o != C_WHITE));

endmodule

// File: rtl/fb_scanout.sv
module fb_scanout
    import fbs_pkg::*;
#(
    parameter int XW      = 7,
    parameter int ROW_W   = 6,
    parameter int PAL_COL = 62
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [XW-1:0]          pix_x,
    input  logic [ROW_W-1:0]       row_y,
    input  logic                   blank,
    input  logic                   cpu_we,
    input  logic [ROW_W+XW-2:0]    cpu_addr,
    input  logic [3:0]             cpu_wdata,
    output logic [2:0]             colour
);
    localparam int COL_W = XW - 1;
    localparam int AW    = ROW_W + COL_W;
    localparam int PAL_X = PAL_COL * 2;

    logic [AW-1:0] rd_addr;
    logic [3:0]    rd_word;
    logic          blank_d;
    logic          odd_d;
    logic [1:0]    pal_sel;
    colour_e       colour_e_q;

    assign rd_addr = {row_y, pix_x[XW-1:1]};

    fbs_frame_mem #(.AW(AW), .DW(4)) u_mem (
        .clk     (clk),
        .wr_en   (cpu_we),
        .wr_addr (cpu_addr),
        .wr_data (cpu_wdata),
        .rd_addr (rd_addr),
        .rd_data (rd_word)
    );

    // Timing flags travel alongside the registered read
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            blank_d <= 1'b1;
            odd_d   <= 1'b0;
        end else begin
            blank_d <= blank;
            odd_d   <= pix_x[0];
        end
    end

    fbs_line_fsm #(.XW(XW), .PAL_X(PAL_X)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .pix_x    (pix_x),
        .word_sel (rd_word[1:0]),
        .pal_sel  (pal_sel)
    );

    fbs_colour_stage u_col (
        .clk      (clk),
        .rst_n    (rst_n),
        .blank_d  (blank_d),
        .odd_d    (odd_d),
        .word_d   (rd_word),
        .pal_sel  (pal_sel),
        .colour_o (colour_e_q)
    );

    assign colour = colour_e_q;

endmodule

// File: tb/fb_scanout_test.sv
module fb_scanout_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [6:0]  pix_x = '0;
    logic [5:0]  row_y = '0;
    logic        blank = 1'b1;
    logic        cpu_we = 1'b0;
    logic [11:0] cpu_addr = '0;
    logic [3:0]  cpu_wdata = '0;
    logic [2:0]  colour;

    always #10 clk = ~clk;

    fb_scanout uut (
        .clk(clk), .rst_n(rst_n), .pix_x(pix_x), .row_y(row_y), .blank(blank),
        .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .colour(colour)
    );

    int checks = 0;
    int errors = 0;

    logic [3:0] shadow [4096];
    logic [1:0] m_pending = 2'd0;
    logic [1:0] m_active  = 2'd0;
    logic [2:0] q_exp [2];
    string      q_tag [2];
    int         q_n = 0;
    string      force_tag = "";

    // Expected colour from the requirement tables (R3, R6)
    function automatic logic [2:0] ref_colour(input logic [1:0] s, input logic [1:0] p);
        if (s == 2'd3) return (p == 2'd0) ? 3'd0 : 3'd1;
        if (p == 2'd1) return 3'd4;
        if (p == 2'd2) return 3'd2;
        if (p == 2'd3) return 3'd3;
        if (s == 2'd0) return 3'd7;
        if (s == 2'd1) return 3'd6;
        return 3'd5;
    endfunction

    function automatic logic is_blank(input int x);
        return (x >= 112) || (x < 8);
    endfunction

    task automatic check(input string tag, input logic [2:0] act, input logic [2:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: colour=%0d expected=%0d at t=%0t", tag, act, exp, $time);
        end
    endtask

    // One pixel clock: check the result of two steps back, then present new inputs
    task automatic step(input int x, input int y, input logic b,
                        input logic we, input logic [11:0] wa, input logic [3:0] wd);
        logic [3:0] w;
        logic [1:0] p;
        logic [2:0] e;
        string      t;
        @(negedge clk);
        if (q_n == 2) begin
            check(q_tag[0], colour, q_exp[0]);
            q_exp[0] = q_exp[1];
            q_tag[0] = q_tag[1];
            q_n = 1;
        end
        pix_x = 7'(x); row_y = 6'(y); blank = b;
        cpu_we = we; cpu_addr = wa; cpu_wdata = wd;
        w = shadow[{6'(y), 6'(x >> 1)}];
        p = x[0] ? w[3:2] : w[1:0];
        e = b ? 3'd0 : ref_colour(m_active, p);
        if (b)                  t = "R4";
        else if (force_tag != "") t = force_tag;
        else if (m_active == 2'd3) t = "R6";
        else                    t = "R3";
        q_exp[q_n] = e;
        q_tag[q_n] = t;
        q_n++;
        if (x == 124) m_pending = w[1:0];
        if (x == 127) m_active = m_pending;
        if (we) shadow[wa] = wd;
    endtask

    task automatic write_word(input int y, input int c, input logic [3:0] d);
        step(0, 0, 1'b1, 1'b1, {6'(y), 6'(c)}, d);
    endtask

    task automatic fill_row(input int y, input int seed, input logic [3:0] palword);
        for (int c = 0; c < 64; c++) begin
            if (c == 62) write_word(y, c, palword);
            else         write_word(y, c, 4'((c * 5 + seed) & 15));
        end
    endtask

    task automatic run_line(input int y);
        for (int x = 0; x < 128; x++) step(x, y, is_blank(x), 1'b0, '0, '0);
    endtask

    // Shows a row for several scanlines; the first is tagged as the stale-palette line (R5)
    task automatic run_row(input int y, input int nlines, input string tag);
        for (int l = 0; l < nlines; l++) begin
            if (l == 0 && m_active != shadow[{6'(y), 6'd62}][1:0]) force_tag = "R5";
            else force_tag = tag;
            run_line(y);
        end
        force_tag = "";
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            check("R1", colour, 3'd0);
        end
        rst_n = 1'b1;
        m_active = 2'd0; m_pending = 2'd0; q_n = 0;
        fill_row(1, 3, 4'b0010);
        // R1: first scanline after reset uses selector 0
        force_tag = "R1";
        run_line(1);
        force_tag = "";
    endtask

    task automatic t_order();
        // R2 and R7: every pixel compared two cycles after its inputs
        run_row(1, 2, "R2");
        fill_row(2, 9, 4'b0000);
        run_row(2, 2, "R7");
    endtask

    task automatic t_palettes();
        fill_row(3, 1, 4'b0001);
        fill_row(4, 6, 4'b0010);
        fill_row(5, 11, 4'b0011);
        fill_row(0, 4, 4'b0000);
        run_row(3, 3, "");
        run_row(4, 3, "");
        run_row(5, 3, "");
        run_row(0, 3, "");
    endtask

    task automatic t_highbits();
        // R9: upper selector bits set, palette must still follow bits [1:0]
        fill_row(6, 2, 4'b1101);
        run_row(6, 2, "R9");
        fill_row(8, 7, 4'b1010);
        run_row(8, 2, "R9");
    endtask

    task automatic t_concurrent();
        // R8: writes to row 7 while row 6 is scanned
        force_tag = "R8";
        for (int x = 0; x < 128; x++)
            step(x, 6, is_blank(x), 1'b1, {6'd7, 6'(x >> 1)},
                 (x >> 1) == 62 ? 4'b0011 : 4'((x * 3 + 1) & 15));
        run_line(7);
        // R8: overwrite the very word being read; the read returns the old word
        for (int x = 0; x < 128; x++)
            step(x, 7, is_blank(x), 1'b1, {6'd7, 6'(x >> 1)},
                 (x >> 1) == 62 ? 4'b0000 : 4'((x * 7 + 5) & 15));
        run_line(7);
        run_line(7);
        force_tag = "";
    endtask

    initial begin
        for (int i = 0; i < 4096; i++) shadow[i] = 4'd0;
        t_reset();
        t_order();
        t_palettes();
        t_highbits();
        t_concurrent();
        for (int i = 0; i < 3; i++) step(0, 0, 1'b1, 1'b0, '0, '0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not complete, actual=timeout expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule